// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A behavioural, synthesizable model of a synchronous static RAM whose address and control pins are captured on the rising clock edge and whose read data leaves through an output register. Each access starts a four-beat burst. An internal two-bit beat counter produces the three follow-on addresses inside the aligned group of four words. A static order pin picks the counting rule: a modulo-4 increment or an XOR of the start offset with the beat index.

A burst opens when either of two active-low start strobes is seen while the chip is selected. The processor strobe always makes its opening cycle a read. The cache-controller strobe lets the write pins act in that cycle. On later cycles, with no strobe, the advance pin steps the counter when low and repeats the current word when high. Writes take effect at the sampling edge and are decided per 9-bit byte lane. The model has a global write, a byte-write enable and one select per lane. Reads appear on the bus one edge after the sampling edge.

The model has no handshake. It has no valid/ready flow and no back-pressure: every selected cycle is an access. The read data bus is modelled as a data vector plus a drive-enable output that stands for the tri-state control. The output enable and the sleep pin act on that drive-enable without a clock.

Top module: `burst_sram`

## Requirements
- R1: A cycle with `strobe_cpu_n` or `strobe_cache_n` low, while selected (`chip_en_n`=0, `sel_hi`=1, `sel_lo_n`=0), opens a burst whose first access uses `addr`.
- R2: A read sampled at edge N is driven on `rdata` with `rdata_en`=1 after edge N+1, for exactly one cycle per beat.
- R3: With `seq_linear`=1, beat k of a burst started at address a uses low bits (a[1:0]+k) mod 4 with the upper bits of a unchanged. Each strobe-free cycle with `advance_n`=0 moves to the next beat.
- R4: With `seq_linear`=0, beat k uses low bits a[1:0] XOR k.
- R5: A strobe-free cycle inside an open burst with `advance_n`=1 accesses the same word as the previous beat.
- R6: `wr_all_n`=0 in a write-capable cycle writes all lanes, whatever `wr_bytes_n` and `lane_sel_n` are. Lane i is bits [9i+8:9i].
- R7: With `wr_all_n`=1 and `wr_bytes_n`=0, only lanes whose `lane_sel_n` bit is 0 are written. The other lanes keep their contents.
- R8: With `wr_all_n`=1 and `wr_bytes_n`=1, the access is a read. With `wr_bytes_n`=0 and every select high, nothing is written and nothing is driven.
- R9: A burst opened by `strobe_cpu_n` is a read in its opening cycle even when the write pins are low. One opened by `strobe_cache_n` obeys the write pins.
- R10: A strobe while not selected closes the burst. Its cycle drives nothing one edge later, and following strobe-free cycles make no access.
- R11: `out_en_n`=1 clears `rdata_en` at once, without waiting for a clock edge.
- R12: `sleep`=1 clears `rdata_en` at once and blocks every access and write. Stored data survives sleep.
- R13: After reset, `rdata_en` is 0 and no burst is open, so strobe-free cycles make no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address, sampled on a start cycle |
| wdata | input | DW | Write data, nine bits per lane |
| rdata | output | DW | Read data from the output register |
| rdata_en | output | 1 | High when the model drives `rdata` |
| strobe_cpu_n | input | 1 | Processor start strobe, active low, read-only opening |
| strobe_cache_n | input | 1 | Cache-controller start strobe, active low |
| advance_n | input | 1 | Low steps the beat counter in strobe-free cycles |
| chip_en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_bytes_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | DW/9 | Per-lane write selects, active low |
| seq_linear | input | 1 | 1 selects increment order, 0 selects XOR order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down, active high |

## Verification
The bench builds the model at its defaults: a 36-bit word with four lanes and a six-bit address. Four lanes let one byte-select pattern mix written and untouched lanes in the same word. The 64-word depth lets bursts start at offsets 1, 2 and 3 inside groups above address 0, so both orders wrap inside a group without spilling into the upper address bits. A scoreboard fed from a requirement-level model compares every cycle's drive-enable and data. It applies the output enable and sleep pins as they stand at the sampling instant, so their effect without a clock is covered too.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANE_BITS = 9;

  // Low two address bits for a beat, by burst order
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
    logic [1:0] r;
    if (linear) r = start + beat;
    else        r = start ^ beat;
    return r;
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic [AW-1:0] addr,
  input  logic          strobe_cpu_n,
  input  logic          strobe_cache_n,
  input  logic          advance_n,
  input  logic          chip_en_n,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic          seq_linear,
  output logic          acc_go,
  output logic          acc_wr_ok,
  output logic [AW-1:0] acc_addr
);
  import burst_sram_pkg::*;

  logic          active_q, active_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    beat_q, beat_d;
  logic          selected, strobe, start_c, cont_c;
  logic [AW-1:0] cur_base;

  assign selected = !chip_en_n && sel_hi && !sel_lo_n;
  assign strobe   = !strobe_cpu_n || !strobe_cache_n;

  always_comb begin
    active_d  = active_q;
    base_d    = base_q;
    beat_d    = beat_q;
    acc_go    = 1'b0;
    acc_wr_ok = 1'b0;
    start_c   = 1'b0;
    cont_c    = 1'b0;
    if (!sleep) begin
      if (strobe && selected) begin
        start_c   = 1'b1;
        acc_go    = 1'b1;
        acc_wr_ok = strobe_cpu_n;
        active_d  = 1'b1;
        base_d    = addr;
        beat_d    = 2'd0;
      end else if (strobe) begin
        active_d = 1'b0;
      end else if (active_q) begin
        cont_c    = 1'b1;
        acc_go    = 1'b1;
        acc_wr_ok = 1'b1;
        if (!advance_n) beat_d = beat_q + 2'd1;
      end
    end
  end

  assign cur_base = start_c ? addr : base_q;
  assign acc_addr = {cur_base[AW-1:2], beat_low(cur_base[1:0], beat_d, seq_linear)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      beat_q   <= beat_d;
    end
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (beat_q == 2'd0 && base_q == $past(addr) && active_q)); // R1

  AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_c && !advance_n) |=> (beat_q == $past(beat_q) + 2'd1)); // R3

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_c && advance_n) |=> $stable(beat_q)); // R5

  AST_DESELECT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe && !selected) |=> !active_q); // R10
endmodule

// File: rtl/lane_write_decode.sv
module lane_write_decode #(
  parameter int LANES = 4
) (
  input  logic             wr_ok,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic             is_write,
  output logic [LANES-1:0] lane_mask
);
  always_comb begin
    is_write  = wr_ok && (!wr_all_n || !wr_bytes_n);
    lane_mask = '0;
    if (wr_ok) begin
      if (!wr_all_n)        lane_mask = '1;
      else if (!wr_bytes_n) lane_mask = ~lane_sel_n;
    end
  end
endmodule

// File: rtl/lane_array.sv
module lane_array #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sleep,
  input  logic                        acc_go,
  input  logic                        is_write,
  input  logic [DW/burst_sram_pkg::LANE_BITS-1:0] lane_mask,
  input  logic [AW-1:0]               acc_addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               out_q,
  output logic                        drive_q
);
  import burst_sram_pkg::*;
  localparam int LANES = DW / LANE_BITS;
  localparam int DEPTH = 1 << AW;

  logic          rd_pend_q;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] rd_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (acc_go && is_write && lane_mask[g])
        store[acc_addr] <= wdata[g*LANE_BITS +: LANE_BITS];
    end
    assign rd_word[g*LANE_BITS +: LANE_BITS] = store[rd_addr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      drive_q   <= 1'b0;
      out_q     <= '0;
    end else begin
      rd_pend_q <= acc_go && !is_write && !sleep;
      if (acc_go) rd_addr_q <= acc_addr;
      drive_q   <= rd_pend_q && !sleep;
      if (rd_pend_q) out_q <= rd_word;
    end
  end

  AST_READ_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend_q && !sleep) |=> drive_q); // R2

  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pend_q |=> !drive_q); // R10

  AST_WRITE_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && is_write) |=> !rd_pend_q); // R8

  AST_SLEEP_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!rd_pend_q && !drive_q)); // R12
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_en,
  input  logic                 strobe_cpu_n,
  input  logic                 strobe_cache_n,
  input  logic                 advance_n,
  input  logic                 chip_en_n,
  input  logic                 sel_hi,
  input  logic                 sel_lo_n,
  input  logic                 wr_all_n,
  input  logic                 wr_bytes_n,
  input  logic [DW/9-1:0]      lane_sel_n,
  input  logic                 seq_linear,
  input  logic                 out_en_n,
  input  logic                 sleep
);
  localparam int LANES = DW / burst_sram_pkg::LANE_BITS;

  logic             acc_go, acc_wr_ok, is_write, drive_q;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] lane_mask;

  burst_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr),
    .strobe_cpu_n(strobe_cpu_n), .strobe_cache_n(strobe_cache_n),
    .advance_n(advance_n), .chip_en_n(chip_en_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .seq_linear(seq_linear),
    .acc_go(acc_go), .acc_wr_ok(acc_wr_ok), .acc_addr(acc_addr)
  );

  lane_write_decode #(.LANES(LANES)) u_dec (
    .wr_ok(acc_wr_ok), .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n),
    .lane_sel_n(lane_sel_n), .is_write(is_write), .lane_mask(lane_mask)
  );

  lane_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .acc_go(acc_go),
    .is_write(is_write), .lane_mask(lane_mask), .acc_addr(acc_addr),
    .wdata(wdata), .out_q(rdata), .drive_q(drive_q)
  );

  assign rdata_en = drive_q && !out_en_n && !sleep;

  AST_CPU_OPEN_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe_cpu_n && !chip_en_n && sel_hi && !sel_lo_n) |-> !is_write); // R9

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdata_en); // R13
endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_en;
  logic          strobe_cpu_n = 1'b1, strobe_cache_n = 1'b1, advance_n = 1'b1;
  logic          chip_en_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_bytes_n = 1'b1;
  logic [3:0]    lane_sel_n = 4'hF;
  logic          seq_linear = 1'b1, out_en_n = 1'b0, sleep = 1'b0;

  always #2 clk = ~clk;

  burst_sram #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_en(rdata_en), .strobe_cpu_n(strobe_cpu_n), .strobe_cache_n(strobe_cache_n),
    .advance_n(advance_n), .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_sel_n(lane_sel_n),
    .seq_linear(seq_linear), .out_en_n(out_en_n), .sleep(sleep)
  );

  typedef struct { int due; bit drv; logic [DW-1:0] data; int req; } exp_t;
  exp_t expq[$];
  exp_t rec;

  int n_run = 0, n_fail = 0, ecount = 0;
  logic [DW-1:0] shadow [64];
  bit            m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always @(posedge clk) ecount++;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, 30'h2A5C_3F01 + 30'(a) * 30'h0101_1011};
  endfunction

  // Monitor: checks each cycle's expected bus state at mid-cycle
  always @(negedge clk) begin
    while (expq.size() > 0 && expq[0].due == ecount) begin
      bit exp_en;
      rec = expq.pop_front();
      exp_en = rec.drv && !out_en_n && !sleep;
      n_run++;
      if (rdata_en !== exp_en) begin
        n_fail++;
        $display("FAIL R%0d: rdata_en=%0b expected %0b", rec.req, rdata_en, exp_en);
      end else if (exp_en && rdata !== rec.data) begin
        n_fail++;
        $display("FAIL R%0d: rdata=%h expected %h", rec.req, rdata, rec.data);
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected result from the requirements
  task automatic step(input int req,
                      input logic cpu_n = 1'b1, input logic cache_n = 1'b1,
                      input logic adv_n = 1'b1, input logic ce_n = 1'b0,
                      input logic wall_n = 1'b1, input logic wbyte_n = 1'b1,
                      input logic [3:0] lsel_n = 4'hF, input logic [AW-1:0] a = '0,
                      input bit auto_wd = 1'b1, input logic [DW-1:0] wd = '0,
                      input logic lin = 1'b1, input logic oe_n = 1'b0,
                      input logic slp = 1'b0);
    bit go, wrok, wr;
    logic [AW-1:0] ad;
    logic [DW-1:0] wv;
    exp_t e;
    @(posedge clk); #1;
    go = 0; wrok = 0;
    if (!slp) begin
      if ((!cpu_n || !cache_n) && !ce_n) begin
        m_base = a; m_beat = 2'd0; m_act = 1; go = 1; wrok = cpu_n;
      end else if (!cpu_n || !cache_n) begin
        m_act = 0;
      end else if (m_act) begin
        go = 1; wrok = 1;
        if (!adv_n) m_beat = m_beat + 2'd1;
      end
    end
    ad = {m_base[AW-1:2], lin ? m_base[1:0] + m_beat : m_base[1:0] ^ m_beat};
    wv = auto_wd ? pat(ad) : wd;
    strobe_cpu_n = cpu_n; strobe_cache_n = cache_n; advance_n = adv_n;
    chip_en_n = ce_n; wr_all_n = wall_n; wr_bytes_n = wbyte_n; lane_sel_n = lsel_n;
    addr = a; wdata = wv; seq_linear = lin; out_en_n = oe_n; sleep = slp;
    e.due = ecount + 2; e.req = req; e.drv = 0; e.data = '0;
    if (go) begin
      wr = wrok && (!wall_n || !wbyte_n);
      if (wr) begin
        for (int i = 0; i < 4; i++)
          if (!wall_n || !lsel_n[i]) shadow[ad][i*9 +: 9] = wv[i*9 +: 9];
      end else begin
        e.drv = 1; e.data = shadow[ad];
      end
    end
    expq.push_back(e);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    n_run++; // R13 reset state
    if (rdata_en !== 1'b0) begin
      n_fail++; $display("FAIL R13: rdata_en=%0b expected 0", rdata_en);
    end
    step(.req(13), .adv_n(0));  // R13: no burst open, no access
    step(.req(13), .adv_n(0));

    // R9, R6, R3: cache-strobe opened bursts write groups 4..7, 8..11, 12..15
    for (int g = 4; g <= 12; g += 4) begin
      step(.req(9), .cache_n(0), .wall_n(0), .a(AW'(g)));
      for (int k = 0; k < 3; k++) step(.req(6), .adv_n(0), .wall_n(0));
    end

    // R1, R2, R3: linear read from offset 2 wraps 6,7,4,5
    step(.req(1), .cpu_n(0), .a(6));
    for (int k = 0; k < 3; k++) step(.req(3), .adv_n(0));

    // R4: XOR order from 9 gives 9,8,11,10
    step(.req(4), .cpu_n(0), .a(9), .lin(0));
    for (int k = 0; k < 3; k++) step(.req(4), .adv_n(0), .lin(0));

    // R5: suspend repeats word 13, then advance to 14
    step(.req(5), .cpu_n(0), .a(13));
    step(.req(5), .adv_n(1));
    step(.req(5), .adv_n(0));

    // R7: lanes 0 and 2 written, 1 and 3 kept
    step(.req(7), .cache_n(0), .wbyte_n(0), .lsel_n(4'b1010), .a(8), .auto_wd(0), .wd('1));
    step(.req(7));

    // R6: global write overrides byte controls with no lane selected
    step(.req(6), .cache_n(0), .wall_n(0), .wbyte_n(0), .lsel_n(4'hF), .a(10),
         .auto_wd(0), .wd(36'h1_2345_6789));
    step(.req(6));

    // R8: byte enable with no lanes: no write, no drive; then plain read
    step(.req(8), .cache_n(0), .wbyte_n(0), .lsel_n(4'hF), .a(11), .auto_wd(0), .wd('0));
    step(.req(8));
    step(.req(8), .cache_n(0), .a(11));

    // R9: processor-opened cycle reads despite global write
    step(.req(9), .cpu_n(0), .wall_n(0), .a(12), .auto_wd(0), .wd('0));
    step(.req(9));

    // R10: deselect ends the burst, later advances make no access
    step(.req(10), .cpu_n(0), .a(4));
    step(.req(10), .cpu_n(0), .ce_n(1));
    step(.req(10), .adv_n(0));
    step(.req(10), .adv_n(0));

    // R11: output enable gates the bus within the cycle
    step(.req(11), .cpu_n(0), .a(5));
    step(.req(11), .adv_n(0), .oe_n(1));
    step(.req(11), .adv_n(0), .oe_n(0));
    step(.req(11), .adv_n(0), .oe_n(1));
    step(.req(11), .cpu_n(0), .ce_n(1));
    step(.req(11), .cpu_n(0), .ce_n(1));

    // R12: sleep gates a pending read, blocks a write, keeps data
    step(.req(12), .cpu_n(0), .a(6));
    step(.req(12), .cpu_n(0), .ce_n(1));
    step(.req(12), .cache_n(0), .wall_n(0), .a(6), .auto_wd(0), .wd('0), .slp(1));
    step(.req(12), .cache_n(0), .wall_n(0), .a(7), .auto_wd(0), .wd('0), .slp(1));
    step(.req(12), .cpu_n(0), .a(6));
    step(.req(12), .adv_n(0));

    step(.req(10), .cpu_n(0), .ce_n(1));
    step(.req(10), .cpu_n(0), .ce_n(1));
    repeat (4) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule